// File: doc/BRIEF.md
# Segmented Memory Access Guard with Vector-Window Override

This block decides, in the same cycle, whether a single memory access may proceed. Each access carries a 16-bit address, a kind (read, write or execute) and a requester (CPU, DMA or debug port). Two programmable boundaries split the address space into three ordinary segments, and each segment has its own read, write and execute rights. A separately programmed encapsulated window can be enabled on top of that. Only code running inside the encapsulated window may touch it.

The top 128 bytes of the address space hold the interrupt and reset vectors. That vector window overrides the normal rules. Vector reads always succeed. Vector fetches fail only when the encapsulated window covers them. Vector writes follow the write right of the ordinary segment while segment checking is on.

A denied access drops the grant output at once. It also latches a sticky violation bit for the cause, and software clears that bit by writing 1 to it. A lock bit freezes the whole configuration until the next reset.

Top module: `mpu_vec_guard`

## Requirements
- R1: The segment index is the number of boundary registers (config address 0 and 1) whose value is less than or equal to the address, giving segments 0, 1 and 2. The rights register (config address 2) holds 3 bits per segment, with segment n in bits [3n+2:3n], bit 0 = read, bit 1 = write and bit 2 = execute. The kind code is 0 for read, 1 for write, 2 for execute and 3 for reserved. Outside the vector and encapsulated windows, with segment checking on (control bit 0), an access is granted exactly when its segment's right for that kind is set. With segment checking off, every such access is granted.
- R2: With the encapsulated window enabled (control bit 1), an address outside the vector window lies inside it when start (config address 3) <= address <= end (config address 4). Such an access is denied when `acc_from_encl` is 0. When `acc_from_encl` is 1, the access is judged as in R1.
- R3: A read at an address in 16'hFF80..16'hFFFF is granted for every requester, whatever the segment rights and the encapsulated window.
- R4: An execute in the vector window is denied whenever the enabled encapsulated window covers the address. Otherwise it is granted, even if the segment has no execute right.
- R5: A write in the vector window is decided by the segment's write bit when segment checking is on. It is granted when segment checking is off, including the case where only the encapsulated window covers it.
- R6: Execute requests from a requester other than the CPU (requester code 0 = CPU, 1 = DMA, 2 = debug) are always denied. So is kind code 3. `acc_grant` is low whenever `acc_valid` is low.
- R7: A denied valid access sets `viol_flags` bit 3 if the denial came from the encapsulated window, and otherwise the bit of its segment. The bit is set on the next clock edge and holds until software writes 1 to it at config address 6. A set in the same cycle wins over a clear.
- R8: Control bit 2 is the lock. Once it is set, writes to config addresses 0 to 5 are ignored and the lock stays set until reset. Flag clearing at address 6 still works while locked.
- R9: After reset, both boundaries are 0, all rights are set, segment checking and the encapsulated window are off, the configuration is unlocked and all flags are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_addr | input | 3 | Configuration register select |
| cfg_wdata | input | 16 | Configuration write data |
| acc_valid | input | 1 | An access is presented this cycle |
| acc_addr | input | 16 | Access address |
| acc_kind | input | 2 | 0 read, 1 write, 2 execute, 3 reserved |
| acc_src | input | 2 | 0 CPU, 1 DMA, 2 debug |
| acc_from_encl | input | 1 | Requester is running code inside the encapsulated window |
| acc_grant | output | 1 | Access allowed (combinational) |
| viol_flags | output | 4 | Sticky violation bits: segments 0 to 2, bit 3 encapsulated window |

## Verification
The assertions are checked on every cycle. They cover the unconditional vector-read grant, the fetch denial inside a covered vector window, the grant being low without a valid access, the latching of a flag after every denial, and the stickiness of the lock. The bench's scenarios cover the remaining behaviour: the full decision under each combination of segment checking, window placement, requester, kind and origin; the write-1-to-clear handling and its priority against a new set; and the lock ignoring later writes.

// File: rtl/mpu_vg_pkg.sv
package mpu_vg_pkg;
    localparam int ADDR_W   = 16;
    localparam int NSEG     = 3;
    localparam int NBND     = NSEG - 1;
    localparam int RIGHT_W  = 3;
    localparam int SEG_W    = $clog2(NSEG);
    localparam int FLAG_W   = NSEG + 1;
    localparam int ENC_FLAG = NSEG;
    localparam int CFG_AW   = 3;

    localparam logic [CFG_AW-1:0] CA_RIGHTS = CFG_AW'(NBND);
    localparam logic [CFG_AW-1:0] CA_ELO    = CFG_AW'(NBND + 1);
    localparam logic [CFG_AW-1:0] CA_EHI    = CFG_AW'(NBND + 2);
    localparam logic [CFG_AW-1:0] CA_CTRL   = CFG_AW'(NBND + 3);
    localparam logic [CFG_AW-1:0] CA_CLR    = CFG_AW'(NBND + 4);

    typedef enum logic [1:0] {ACC_READ = 2'd0, ACC_WRITE = 2'd1,
                              ACC_EXEC = 2'd2, ACC_RSVD = 2'd3} acc_kind_e;
    typedef enum logic [1:0] {SRC_CPU = 2'd0, SRC_DMA = 2'd1,
                              SRC_DBG = 2'd2, SRC_RSVD = 2'd3} acc_src_e;

    typedef struct packed {
        logic [NBND-1:0][ADDR_W-1:0]  bnd;
        logic [NSEG-1:0][RIGHT_W-1:0] rights;
        logic [ADDR_W-1:0]            encl_lo;
        logic [ADDR_W-1:0]            encl_hi;
        logic                         mpu_en;
        logic                         encl_en;
        logic                         lock;
    } mpu_cfg_t;

    typedef struct packed {
        logic              in_vec;
        logic              in_encl;
        logic [SEG_W-1:0]  seg;
    } region_t;

    typedef struct packed {
        logic ok;
        logic encl_cause;
    } verdict_t;

    function automatic verdict_t mpu_decide(region_t rg, logic from_encl, logic mpu_en,
                                            logic [RIGHT_W-1:0] rt, acc_kind_e kind,
                                            acc_src_e src);
        verdict_t v;
        v.ok = 1'b0;
        v.encl_cause = 1'b0;
        if (kind == ACC_RSVD || (kind == ACC_EXEC && src != SRC_CPU)) begin
            v.ok = 1'b0;
        end else if (rg.in_vec) begin
            case (kind)
                ACC_READ: v.ok = 1'b1;
                ACC_EXEC: begin
                    v.ok = !rg.in_encl;
                    v.encl_cause = rg.in_encl;
                end
                default:  v.ok = !mpu_en || rt[1];
            endcase
        end else if (rg.in_encl && !from_encl) begin
            v.encl_cause = 1'b1;
        end else begin
            v.ok = !mpu_en || rt[kind];
        end
        return v;
    endfunction
endpackage

// File: rtl/mpu_cfg_regs.sv
module mpu_cfg_regs
    import mpu_vg_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              cfg_we,
    input  logic [CFG_AW-1:0] cfg_addr,
    input  logic [15:0]       cfg_wdata,
    output mpu_cfg_t          cfg_q,
    output logic [FLAG_W-1:0] clr_mask
);
    logic wr_ok;
    assign wr_ok    = cfg_we && !cfg_q.lock;
    assign clr_mask = (cfg_we && cfg_addr == CA_CLR) ? cfg_wdata[FLAG_W-1:0] : '0;

    always_ff @(posedge clk) begin
        if (rst) begin
            cfg_q.rights  <= '1;
            cfg_q.encl_lo <= '0;
            cfg_q.encl_hi <= '0;
            cfg_q.mpu_en  <= 1'b0;
            cfg_q.encl_en <= 1'b0;
            cfg_q.lock    <= 1'b0;
        end else if (wr_ok) begin
            case (cfg_addr)
                CA_RIGHTS: cfg_q.rights  <= cfg_wdata[NSEG*RIGHT_W-1:0];
                CA_ELO:    cfg_q.encl_lo <= cfg_wdata[ADDR_W-1:0];
                CA_EHI:    cfg_q.encl_hi <= cfg_wdata[ADDR_W-1:0];
                CA_CTRL: begin
                    cfg_q.mpu_en  <= cfg_wdata[0];
                    cfg_q.encl_en <= cfg_wdata[1];
                    cfg_q.lock    <= cfg_wdata[2];
                end
                default: ;
            endcase
        end
    end

    for (genvar b = 0; b < NBND; b++) begin : g_bnd
        always_ff @(posedge clk) begin
            if (rst)
                cfg_q.bnd[b] <= '0;
            else if (wr_ok && cfg_addr == CFG_AW'(b))
                cfg_q.bnd[b] <= cfg_wdata[ADDR_W-1:0];
        end
    end
endmodule

// File: rtl/mpu_region_decode.sv
module mpu_region_decode
    import mpu_vg_pkg::*;
#(
    parameter logic [ADDR_W-1:0] VEC_BASE = 16'hFF80
) (
    input  logic [ADDR_W-1:0] addr,
    input  mpu_cfg_t          cfg,
    output region_t           rg
);
    logic [NBND-1:0] above;

    for (genvar b = 0; b < NBND; b++) begin : g_cmp
        assign above[b] = addr >= cfg.bnd[b];
    end

    always_comb begin
        rg.seg     = SEG_W'($countones(above));
        rg.in_vec  = addr >= VEC_BASE;
        rg.in_encl = cfg.encl_en && addr >= cfg.encl_lo && addr <= cfg.encl_hi;
    end
endmodule

// File: rtl/mpu_viol_flags.sv
module mpu_viol_flags
    import mpu_vg_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic [FLAG_W-1:0] set_mask,
    input  logic [FLAG_W-1:0] clr_mask,
    output logic [FLAG_W-1:0] flags
);
    for (genvar i = 0; i < FLAG_W; i++) begin : g_flag
        always_ff @(posedge clk) begin
            if (rst)
                flags[i] <= 1'b0;
            else
                flags[i] <= (flags[i] && !clr_mask[i]) || set_mask[i];
        end
    end
endmodule

// File: rtl/mpu_vec_guard.sv
module mpu_vec_guard
    import mpu_vg_pkg::*;
#(
    parameter logic [ADDR_W-1:0] VEC_BASE = 16'hFF80
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              cfg_we,
    input  logic [CFG_AW-1:0] cfg_addr,
    input  logic [15:0]       cfg_wdata,
    input  logic              acc_valid,
    input  logic [ADDR_W-1:0] acc_addr,
    input  logic [1:0]        acc_kind,
    input  logic [1:0]        acc_src,
    input  logic              acc_from_encl,
    output logic              acc_grant,
    output logic [FLAG_W-1:0] viol_flags
);
    mpu_cfg_t          cfg_q;
    logic [FLAG_W-1:0] clr_mask;
    logic [FLAG_W-1:0] set_mask;
    region_t           rg;
    verdict_t          vd;

    mpu_cfg_regs u_cfg (
        .clk(clk), .rst(rst), .cfg_we(cfg_we), .cfg_addr(cfg_addr),
        .cfg_wdata(cfg_wdata), .cfg_q(cfg_q), .clr_mask(clr_mask)
    );

    mpu_region_decode #(.VEC_BASE(VEC_BASE)) u_dec (
        .addr(acc_addr), .cfg(cfg_q), .rg(rg)
    );

    always_comb begin
        vd = mpu_decide(rg, acc_from_encl, cfg_q.mpu_en, cfg_q.rights[rg.seg],
                        acc_kind_e'(acc_kind), acc_src_e'(acc_src));
        acc_grant = acc_valid && vd.ok;
        set_mask  = '0;
        if (acc_valid && !vd.ok) begin
            if (vd.encl_cause)
                set_mask[ENC_FLAG] = 1'b1;
            else
                set_mask[rg.seg] = 1'b1;
        end
    end

    mpu_viol_flags u_flags (
        .clk(clk), .rst(rst), .set_mask(set_mask), .clr_mask(clr_mask),
        .flags(viol_flags)
    );
endmodule

// File: rtl/mpu_vec_guard_chk.sv
module mpu_vec_guard_chk
    import mpu_vg_pkg::*;
#(
    parameter logic [ADDR_W-1:0] VEC_BASE = 16'hFF80
) (
    input logic              clk,
    input logic              rst,
    input logic              acc_valid,
    input logic [ADDR_W-1:0] acc_addr,
    input logic [1:0]        acc_kind,
    input logic              acc_grant,
    input logic [FLAG_W-1:0] viol_flags,
    input logic              encl_en,
    input logic [ADDR_W-1:0] encl_lo,
    input logic [ADDR_W-1:0] encl_hi,
    input logic              lock
);
    assert_vec_read_R3: assert property (@(posedge clk) disable iff (rst)
        (acc_valid && acc_addr >= VEC_BASE && acc_kind == 2'd0) |-> acc_grant);

    assert_vec_exec_encl_R4: assert property (@(posedge clk) disable iff (rst)
        (acc_valid && acc_addr >= VEC_BASE && acc_kind == 2'd2 && encl_en &&
         acc_addr >= encl_lo && acc_addr <= encl_hi) |-> !acc_grant);

    assert_grant_needs_valid_R6: assert property (@(posedge clk) disable iff (rst)
        !acc_valid |-> !acc_grant);

    assert_deny_flags_R7: assert property (@(posedge clk) disable iff (rst)
        (acc_valid && !acc_grant) |=> (viol_flags != '0));

    assert_lock_sticky_R8: assert property (@(posedge clk) disable iff (rst)
        lock |=> lock);
endmodule

bind mpu_vec_guard mpu_vec_guard_chk #(.VEC_BASE(VEC_BASE)) u_chk (
    .clk(clk), .rst(rst), .acc_valid(acc_valid), .acc_addr(acc_addr),
    .acc_kind(acc_kind), .acc_grant(acc_grant), .viol_flags(viol_flags),
    .encl_en(cfg_q.encl_en), .encl_lo(cfg_q.encl_lo), .encl_hi(cfg_q.encl_hi),
    .lock(cfg_q.lock)
);

// File: tb/mpu_vec_guard_test.sv
`timescale 1ns/1ps
module mpu_vec_guard_test;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        cfg_we = 1'b0;
    logic [2:0]  cfg_addr = '0;
    logic [15:0] cfg_wdata = '0;
    logic        acc_valid = 1'b0;
    logic [15:0] acc_addr = '0;
    logic [1:0]  acc_kind = '0;
    logic [1:0]  acc_src = '0;
    logic        acc_from_encl = 1'b0;
    logic        acc_grant;
    logic [3:0]  viol_flags;

    int checks = 0;
    int failures = 0;

    // bench-side view of the configuration written so far
    logic [15:0] s_b1, s_b2, s_lo, s_hi;
    logic [8:0]  s_rights;
    logic        s_mpu, s_encl, s_lock;

    always #5 clk = ~clk;

    mpu_vec_guard uut (
        .clk(clk), .rst(rst), .cfg_we(cfg_we), .cfg_addr(cfg_addr), .cfg_wdata(cfg_wdata),
        .acc_valid(acc_valid), .acc_addr(acc_addr), .acc_kind(acc_kind), .acc_src(acc_src),
        .acc_from_encl(acc_from_encl), .acc_grant(acc_grant), .viol_flags(viol_flags)
    );

    task automatic check(string req, logic [31:0] act, logic [31:0] exp, string what);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst = 1'b1; acc_valid = 1'b0; cfg_we = 1'b0;
        @(negedge clk);
        @(negedge clk);
        rst = 1'b0;
        s_b1 = 0; s_b2 = 0; s_lo = 0; s_hi = 0; s_rights = 9'h1FF;
        s_mpu = 0; s_encl = 0; s_lock = 0;
    endtask

    task automatic cfg_write(logic [2:0] a, logic [15:0] d);
        @(negedge clk);
        cfg_we = 1'b1; cfg_addr = a; cfg_wdata = d;
        @(negedge clk);
        cfg_we = 1'b0;
        if (!s_lock) begin
            case (a)
                3'd0: s_b1 = d;
                3'd1: s_b2 = d;
                3'd2: s_rights = d[8:0];
                3'd3: s_lo = d;
                3'd4: s_hi = d;
                3'd5: begin s_mpu = d[0]; s_encl = d[1]; s_lock = d[2]; end
                default: ;
            endcase
        end
    endtask

    // decision taken from the requirement text; boundaries are written in order
    function automatic bit ref_ok(logic [15:0] a, logic [1:0] k, logic [1:0] s, bit fr);
        bit vec = (a >= 16'hFF80);
        bit enc = s_encl && (a >= s_lo) && (a <= s_hi);
        int sg = (a >= s_b2) ? 2 : ((a >= s_b1) ? 1 : 0);
        logic [2:0] r = s_rights[sg*3 +: 3];
        if (k == 2'd3) return 1'b0;
        if (k == 2'd2 && s != 2'd0) return 1'b0;
        if (vec) begin
            if (k == 2'd0) return 1'b1;
            if (k == 2'd2) return !enc;
            return s_mpu ? r[1] : 1'b1;
        end
        if (enc && !fr) return 1'b0;
        return s_mpu ? r[k] : 1'b1;
    endfunction

    function automatic string tag_of(logic [15:0] a, logic [1:0] k, logic [1:0] s);
        bit enc = s_encl && (a >= s_lo) && (a <= s_hi);
        if (k == 2'd3 || (k == 2'd2 && s != 2'd0)) return "R6";
        if (a >= 16'hFF80) begin
            if (k == 2'd0) return "R3";
            if (k == 2'd2) return "R4";
            return "R5";
        end
        if (enc) return "R2";
        return "R1";
    endfunction

    task automatic probe(string req, logic [15:0] a, logic [1:0] k, logic [1:0] s, bit fr,
                         bit exp);
        @(negedge clk);
        acc_valid = 1'b1; acc_addr = a; acc_kind = k; acc_src = s; acc_from_encl = fr;
        #1;
        check(req, {31'd0, acc_grant}, {31'd0, exp}, $sformatf("grant a=%h k=%0d s=%0d", a, k, s));
    endtask

    task automatic idle();
        @(negedge clk);
        acc_valid = 1'b0;
    endtask

    // R9: state straight after reset
    task automatic t_reset_state();
        do_reset();
        #1;
        check("R9", {28'd0, viol_flags}, 32'd0, "flags after reset");
        check("R6", {31'd0, acc_grant}, 32'd0, "grant with no valid access");
        probe("R9", 16'h0010, 2'd1, 2'd1, 1'b0, 1'b1);
        probe("R9", 16'h9000, 2'd2, 2'd0, 1'b0, 1'b1);
        probe("R6", 16'h9000, 2'd2, 2'd1, 1'b0, 1'b0);
        idle();
    endtask

    // R1..R6: every requester, kind and origin over one configuration
    task automatic t_sweep(logic mpu, logic encl, logic [15:0] lo, logic [15:0] hi,
                           logic [8:0] rights);
        logic [15:0] addrs [6] = '{16'h0010, 16'h4100, 16'h9000, 16'hFF7F, 16'hFF80, 16'hFFFF};
        do_reset();
        cfg_write(3'd0, 16'h4000);
        cfg_write(3'd1, 16'h8000);
        cfg_write(3'd2, {7'd0, rights});
        cfg_write(3'd3, lo);
        cfg_write(3'd4, hi);
        cfg_write(3'd5, {14'd0, encl, mpu});
        for (int ai = 0; ai < 6; ai++)
            for (int k = 0; k < 4; k++)
                for (int s = 0; s < 3; s++)
                    for (int f = 0; f < 2; f++)
                        probe(tag_of(addrs[ai], 2'(k), 2'(s)), addrs[ai], 2'(k), 2'(s), f[0],
                              ref_ok(addrs[ai], 2'(k), 2'(s), f[0]));
        idle();
        #1;
        check("R6", {31'd0, acc_grant}, 32'd0, "grant after valid drops");
    endtask

    // R7: sticky flags, write-1-to-clear and set priority
    task automatic t_flags();
        do_reset();
        cfg_write(3'd0, 16'h4000);
        cfg_write(3'd1, 16'h8000);
        cfg_write(3'd2, 16'h01F8);          // segment 0 has no rights
        cfg_write(3'd3, 16'h4000);
        cfg_write(3'd4, 16'h4FFF);
        cfg_write(3'd5, 16'h0003);
        probe("R1", 16'h0010, 2'd0, 2'd0, 1'b0, 1'b0);
        idle();
        #1;
        check("R7", {28'd0, viol_flags}, 32'h1, "segment 0 flag");
        probe("R2", 16'h4100, 2'd0, 2'd1, 1'b0, 1'b0);
        idle();
        #1;
        check("R7", {28'd0, viol_flags}, 32'h9, "encapsulated flag added");
        repeat (3) @(negedge clk);
        check("R7", {28'd0, viol_flags}, 32'h9, "flags hold");
        cfg_write(3'd6, 16'h0001);
        #1;
        check("R7", {28'd0, viol_flags}, 32'h8, "clear bit 0");
        // clear and new denial in the same cycle: set wins
        @(negedge clk);
        acc_valid = 1'b1; acc_addr = 16'h0020; acc_kind = 2'd1; acc_src = 2'd0;
        acc_from_encl = 1'b0;
        cfg_we = 1'b1; cfg_addr = 3'd6; cfg_wdata = 16'h0009;
        @(negedge clk);
        acc_valid = 1'b0; cfg_we = 1'b0;
        #1;
        check("R7", {28'd0, viol_flags}, 32'h1, "set wins over clear");
    endtask

    // R8: lock freezes configuration until reset
    task automatic t_lock();
        do_reset();
        cfg_write(3'd0, 16'h4000);
        cfg_write(3'd1, 16'h8000);
        cfg_write(3'd2, 16'h01F8);
        cfg_write(3'd5, 16'h0005);          // checking on, locked
        cfg_write(3'd2, 16'h01FF);          // ignored
        cfg_write(3'd5, 16'h0000);          // ignored
        probe("R8", 16'h0010, 2'd0, 2'd0, 1'b0, 1'b0);
        idle();
        #1;
        check("R8", {28'd0, viol_flags}, 32'h1, "locked rights still deny");
        cfg_write(3'd6, 16'h000F);
        #1;
        check("R8", {28'd0, viol_flags}, 32'h0, "clear works while locked");
        do_reset();
        cfg_write(3'd2, 16'h01F8);
        probe("R8", 16'h0010, 2'd0, 2'd0, 1'b0, 1'b1);
        idle();
    endtask

    initial begin
        t_reset_state();
        t_sweep(1'b1, 1'b0, 16'h0000, 16'h0000, 9'b000_011_111);
        t_sweep(1'b1, 1'b1, 16'h4000, 16'h4FFF, 9'b100_011_001);
        t_sweep(1'b0, 1'b1, 16'hFF00, 16'hFFFF, 9'b000_000_000);
        t_sweep(1'b1, 1'b1, 16'hFF00, 16'hFFFF, 9'b010_111_111);
        t_sweep(1'b1, 1'b1, 16'hFF00, 16'hFFFF, 9'b100_111_111);
        t_flags();
        t_lock();
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        checks++;
        failures++;
        $display("FAIL watchdog run did not finish actual=hung expected=done");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule